// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the status and protection state of a small serial NOR flash. A command decoder elsewhere turns serial instructions into one-cycle strobes. The block answers those strobes. It tracks whether a program or erase is running, whether writes are currently enabled, and which end of the array is locked against modification. It also times each long operation with an internal counter. A status byte is available at all times, and a registered copy is returned for each status-read strobe. A second address input lets the array controller ask at any moment whether a byte lies in the locked region.

The protection fields (two block-protect bits, a top/bottom select bit and a register-protect bit) behave like non-volatile storage. The power-up reset leaves them alone, and only a separate factory-reset input loads their defaults. The write-enable latch and the busy flag are volatile. They return to 0 on the power-up reset.

Top module: `sflash_status_ctl`

## Requirements
- R1: The status byte is laid out as bit 0 busy, bit 1 write-enable latch, bits 3:2 block-protect (bit 3 is the upper bit), bit 5 top/bottom select, bit 7 register-protect. Bits 4 and 6 always read 0. A status-write data byte uses the same bit positions for the four writable fields.
- R2: The power-up reset (rst_n low) clears busy and the write-enable latch at once and leaves the four protection fields unchanged. A factory-reset cycle loads all four protection fields with 0.
- R3: When idle, a write-enable strobe sets the latch and a write-disable strobe clears it.
- R4: When idle with the latch at 1, a status-write strobe raises busy for T_WRSR cycles. When it completes, the data byte's fields are stored and the latch is cleared. With the latch at 0 the strobe has no effect.
- R5: If the register-protect bit is 1 and wp_n is 0 when a status write is issued, the write still runs and clears the latch, but all four protection fields keep their values.
- R6: A program, sector erase, block erase or chip erase that is accepted raises busy for T_PP, T_SE, T_BE or T_CE cycles respectively. It clears the latch on completion.
- R7: A program or erase is rejected if the latch is 0 or if its span touches the protected region. When rejected, busy stays 0 and the latch keeps its value. The spans are: program uses one byte, sector erase the aligned 2^SECTOR_W bytes, block erase the aligned 2^BLOCK_W bytes, and chip erase the whole array.
- R8: While busy is 1, every strobe except status read is ignored. This includes a strobe in the cycle in which the operation completes.
- R9: A status-read strobe yields rd_valid in the next cycle, with rd_byte equal to the status byte at the strobe. This works both while busy and while idle.
- R10: The protected region is as follows. Block-protect 0 protects nothing. Block-protect 1 protects 2^(ADDR_W-FRAC_LOG2) bytes. Block-protect 2 protects twice that. Block-protect 3 protects the whole array. Top/bottom 0 places the region at the highest addresses and 1 at the lowest. query_prot reports the region for query_addr combinationally.
- R11: If several strobes arrive together while idle, status write wins over program, program over sector erase, then block erase, then chip erase, then write disable, then write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| factory_rst | input | 1 | Synchronous load of protection defaults |
| wren_stb | input | 1 | Write-enable instruction strobe |
| wrdi_stb | input | 1 | Write-disable instruction strobe |
| rdsr_stb | input | 1 | Status-read instruction strobe |
| wrsr_stb | input | 1 | Status-write instruction strobe |
| wrsr_byte | input | 8 | Data byte of the status write |
| prog_stb | input | 1 | Page-program strobe |
| sec_erase_stb | input | 1 | Sector-erase strobe |
| blk_erase_stb | input | 1 | Block-erase strobe |
| chip_erase_stb | input | 1 | Chip-erase strobe |
| op_addr | input | ADDR_W | Target address of program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| query_addr | input | ADDR_W | Address to test against the protected region |
| query_prot | output | 1 | query_addr lies in the protected region |
| status | output | 8 | Live status byte |
| rd_valid | output | 1 | Status-read response valid |
| rd_byte | output | 8 | Status byte captured at the read strobe |

## Verification
The critical coincidence is an operation finishing in the same cycle as a new strobe arrives. The bench counts the countdown to the cycle whose edge ends a program. It then places a write-enable strobe on that edge and expects busy and the latch to both be 0 afterwards, because completion wins and the strobe is dropped. A second coincidence is two strobes together while idle. Write enable with write disable, and status write with program, are issued in one cycle. The outcome is judged by which duration busy lasts and by the final byte.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_WRSR,
      OP_PP,
      OP_SE,
      OP_BE,
      OP_CE
   } op_kind_e;

   typedef struct packed {
      logic       srp;
      logic       tb;
      logic [1:0] bp;
   } nv_t;

   localparam nv_t NV_DEFAULT = '{srp: 1'b0, tb: 1'b0, bp: 2'b00};

   localparam int SR_BUSY = 0;
   localparam int SR_WEL  = 1;
   localparam int SR_BP0  = 2;
   localparam int SR_BP1  = 3;
   localparam int SR_TB   = 5;
   localparam int SR_SRP  = 7;

   function automatic logic [7:0] pack_status(nv_t nv, logic wel, logic busy);
      logic [7:0] s;
      s = 8'h00;
      s[SR_BUSY] = busy;
      s[SR_WEL]  = wel;
      s[SR_BP0]  = nv.bp[0];
      s[SR_BP1]  = nv.bp[1];
      s[SR_TB]   = nv.tb;
      s[SR_SRP]  = nv.srp;
      return s;
   endfunction

   function automatic nv_t unpack_nv(logic [7:0] b);
      nv_t n;
      n.srp = b[SR_SRP];
      n.tb  = b[SR_TB];
      n.bp  = {b[SR_BP1], b[SR_BP0]};
      return n;
   endfunction

endpackage

// File: rtl/sfs_region_map.sv
module sfs_region_map #(
   parameter int ADDR_W    = 17,
   parameter int FRAC_LOG2 = 3
) (
   input  logic [1:0]        bp,
   input  logic              tb,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam int LO_BASE = ADDR_W - FRAC_LOG2;

   if (FRAC_LOG2 < 2 || FRAC_LOG2 >= ADDR_W) begin : g_bad_frac
      $error("sfs_region_map: FRAC_LOG2 must lie in [2, ADDR_W-1]");
   end

   logic [1:0] lvl_hit;

   // One level per non-trivial protect code: the region is the aligned
   // span whose address bits above LO are all ones (top) or all zeros (bottom).
   for (genvar k = 0; k < 2; k++) begin : g_lvl
      localparam int LO = LO_BASE + k;
      logic [ADDR_W-1-LO:0] upper;
      assign upper      = addr[ADDR_W-1:LO];
      assign lvl_hit[k] = tb ? ~|upper : &upper;
   end

   always_comb begin
      unique case (bp)
         2'd0:    hit = 1'b0;
         2'd1:    hit = lvl_hit[0];
         2'd2:    hit = lvl_hit[1];
         default: hit = 1'b1;
      endcase
   end

endmodule

// File: rtl/sfs_op_timer.sv
module sfs_op_timer
   import sfs_pkg::*;
#(
   parameter int T_WRSR = 1500,
   parameter int T_PP   = 800,
   parameter int T_SE   = 30000,
   parameter int T_BE   = 150000,
   parameter int T_CE   = 600000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  op_kind_e op,
   output logic     busy,
   output logic     done
);

   localparam int M1    = (T_WRSR > T_PP) ? T_WRSR : T_PP;
   localparam int M2    = (M1 > T_SE) ? M1 : T_SE;
   localparam int M3    = (M2 > T_BE) ? M2 : T_BE;
   localparam int T_MAX = (M3 > T_CE) ? M3 : T_CE;
   localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

   if (T_WRSR < 1 || T_PP < 1 || T_SE < 1 || T_BE < 1 || T_CE < 1) begin : g_bad_dur
      $error("sfs_op_timer: every duration must be at least one cycle");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      unique case (op)
         OP_WRSR: load_val = CNT_W'(T_WRSR - 1);
         OP_PP:   load_val = CNT_W'(T_PP - 1);
         OP_SE:   load_val = CNT_W'(T_SE - 1);
         OP_BE:   load_val = CNT_W'(T_BE - 1);
         OP_CE:   load_val = CNT_W'(T_CE - 1);
         default: load_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= load_val;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign done = busy && (cnt == '0);

   // R6: busy only falls after a completion cycle
   assert_fall_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

endmodule

// File: rtl/sfs_nv_bits.sv
module sfs_nv_bits
   import sfs_pkg::*;
(
   input  logic clk,
   input  logic factory_rst,
   input  logic wr_en,
   input  nv_t  wr_val,
   output nv_t  q
);

   // Deliberately untouched by the power-up reset.
   always_ff @(posedge clk) begin
      if (factory_rst) q <= NV_DEFAULT;
      else if (wr_en)  q <= wr_val;
   end

endmodule

// File: rtl/sflash_status_ctl.sv
module sflash_status_ctl
   import sfs_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int SECTOR_W  = 12,
   parameter int BLOCK_W   = 16,
   parameter int FRAC_LOG2 = 3,
   parameter int T_WRSR    = 1500,
   parameter int T_PP      = 800,
   parameter int T_SE      = 30000,
   parameter int T_BE      = 150000,
   parameter int T_CE      = 600000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              factory_rst,
   input  logic              wren_stb,
   input  logic              wrdi_stb,
   input  logic              rdsr_stb,
   input  logic              wrsr_stb,
   input  logic [7:0]        wrsr_byte,
   input  logic              prog_stb,
   input  logic              sec_erase_stb,
   input  logic              blk_erase_stb,
   input  logic              chip_erase_stb,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] query_addr,
   output logic              query_prot,
   output logic [7:0]        status,
   output logic              rd_valid,
   output logic [7:0]        rd_byte
);

   localparam logic [ADDR_W-1:0] SEC_MASK = ADDR_W'((64'd1 << SECTOR_W) - 64'd1);
   localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((64'd1 << BLOCK_W) - 64'd1);
   localparam logic [ADDR_W-1:0] ALL_ONES = '1;

   if (SECTOR_W < 1 || SECTOR_W >= BLOCK_W || BLOCK_W > ADDR_W) begin : g_bad_geom
      $error("sflash_status_ctl: need 1 <= SECTOR_W < BLOCK_W <= ADDR_W");
   end

   logic     busy, done, wel, start;
   logic     do_wren, do_wrdi, accept_wrsr, accept_prog, span_prot;
   logic     pend_wrsr, pend_lock, nv_wr_en;
   nv_t      nv_q, pend_val;
   op_kind_e pick;
   logic [ADDR_W-1:0] span_lo, span_hi;

   // ---------------- command selection (fixed priority) ----------------
   always_comb begin
      pick = OP_NONE;
      if (!busy) begin
         if      (wrsr_stb)       pick = OP_WRSR;
         else if (prog_stb)       pick = OP_PP;
         else if (sec_erase_stb)  pick = OP_SE;
         else if (blk_erase_stb)  pick = OP_BE;
         else if (chip_erase_stb) pick = OP_CE;
      end
   end

   assign do_wrdi = !busy && (pick == OP_NONE) && wrdi_stb;
   assign do_wren = !busy && (pick == OP_NONE) && !wrdi_stb && wren_stb;

   // ---------------- span of the modifying operation ----------------
   always_comb begin
      unique case (pick)
         OP_SE: begin
            span_lo = op_addr & ~SEC_MASK;
            span_hi = op_addr | SEC_MASK;
         end
         OP_BE: begin
            span_lo = op_addr & ~BLK_MASK;
            span_hi = op_addr | BLK_MASK;
         end
         OP_CE: begin
            span_lo = '0;
            span_hi = ALL_ONES;
         end
         default: begin
            span_lo = op_addr;
            span_hi = op_addr;
         end
      endcase
   end

   // Region is anchored at one end of the array, so a span overlaps it
   // exactly when one of its end points lies inside.
   logic [2:0]        map_hit;
   logic [ADDR_W-1:0] map_addr [3];
   assign map_addr[0] = query_addr;
   assign map_addr[1] = span_lo;
   assign map_addr[2] = span_hi;

   for (genvar i = 0; i < 3; i++) begin : g_map
      sfs_region_map #(
         .ADDR_W   (ADDR_W),
         .FRAC_LOG2(FRAC_LOG2)
      ) u_map (
         .bp  (nv_q.bp),
         .tb  (nv_q.tb),
         .addr(map_addr[i]),
         .hit (map_hit[i])
      );
   end

   assign query_prot = map_hit[0];
   assign span_prot  = map_hit[1] | map_hit[2];

   assign accept_wrsr = (pick == OP_WRSR) && wel;
   assign accept_prog = (pick inside {OP_PP, OP_SE, OP_BE, OP_CE}) && wel && !span_prot;
   assign start       = accept_wrsr || accept_prog;

   // ---------------- operation timer ----------------
   sfs_op_timer #(
      .T_WRSR(T_WRSR),
      .T_PP  (T_PP),
      .T_SE  (T_SE),
      .T_BE  (T_BE),
      .T_CE  (T_CE)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .op   (pick),
      .busy (busy),
      .done (done)
   );

   // ---------------- pending status write ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_wrsr <= 1'b0;
         pend_lock <= 1'b0;
         pend_val  <= NV_DEFAULT;
      end else if (start) begin
         pend_wrsr <= accept_wrsr;
         pend_lock <= nv_q.srp && !wp_n;
         pend_val  <= unpack_nv(wrsr_byte);
      end
   end

   assign nv_wr_en = done && pend_wrsr && !pend_lock;

   sfs_nv_bits u_nv (
      .clk        (clk),
      .factory_rst(factory_rst),
      .wr_en      (nv_wr_en),
      .wr_val     (pend_val),
      .q          (nv_q)
   );

   // ---------------- write enable latch ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wel <= 1'b0;
      else if (done)    wel <= 1'b0;
      else if (do_wrdi) wel <= 1'b0;
      else if (do_wren) wel <= 1'b1;
   end

   // ---------------- status output and read response ----------------
   assign status = pack_status(nv_q, wel, busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_byte  <= 8'h00;
      end else begin
         rd_valid <= rdsr_stb;
         if (rdsr_stb) rd_byte <= status;
      end
   end

   // ---------------- assertions ----------------
   assert_wren_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      do_wren |=> wel);

   assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!wel && !busy));

   assert_reject_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pick inside {OP_PP, OP_SE, OP_BE, OP_CE}) && (!wel || span_prot))
         |=> (!busy && (wel == $past(wel))));

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && (wel == $past(wel))));

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   assert_lock_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pend_lock && !factory_rst) |=> (nv_q == $past(nv_q)));

   assert_read_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rdsr_stb |=> (rd_valid && (rd_byte == $past(status))));

   assert_bp_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_q.bp == 2'd0) |-> !query_prot);

   assert_bp_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_q.bp == 2'd3) |-> query_prot);

endmodule

// File: tb/tb_sflash_status_ctl.sv
module tb_sflash_status_ctl;

   localparam int AW   = 17;
   localparam int FL   = 3;
   localparam int D_SR = 6;
   localparam int D_PP = 3;
   localparam int D_SE = 5;
   localparam int D_BE = 7;
   localparam int D_CE = 9;

   localparam int C_WREN = 0, C_WRDI = 1, C_RDSR = 2, C_WRSR = 3,
                  C_PP = 4, C_SE = 5, C_BE = 6, C_CE = 7;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0, factory_rst = 1'b0;
   logic          wren = 0, wrdi = 0, rdsr = 0, wrsr = 0, pp = 0, se = 0, be = 0, ce = 0;
   logic [7:0]    wdata = 8'h00;
   logic [AW-1:0] addr = '0, qaddr = '0;
   logic          wp_n = 1'b1;
   logic          qprot, rd_valid;
   logic [7:0]    status, rd_byte;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   sflash_status_ctl #(
      .ADDR_W(AW), .SECTOR_W(12), .BLOCK_W(16), .FRAC_LOG2(FL),
      .T_WRSR(D_SR), .T_PP(D_PP), .T_SE(D_SE), .T_BE(D_BE), .T_CE(D_CE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .factory_rst(factory_rst),
      .wren_stb(wren), .wrdi_stb(wrdi), .rdsr_stb(rdsr), .wrsr_stb(wrsr),
      .wrsr_byte(wdata), .prog_stb(pp), .sec_erase_stb(se), .blk_erase_stb(be),
      .chip_erase_stb(ce), .op_addr(addr), .wp_n(wp_n), .query_addr(qaddr),
      .query_prot(qprot), .status(status), .rd_valid(rd_valid), .rd_byte(rd_byte)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input int c, input logic v);
      case (c)
         C_WREN: wren = v;
         C_WRDI: wrdi = v;
         C_RDSR: rdsr = v;
         C_WRSR: wrsr = v;
         C_PP:   pp   = v;
         C_SE:   se   = v;
         C_BE:   be   = v;
         default: ce  = v;
      endcase
   endtask

   task automatic issue2(input int c1, input int c2, input logic [7:0] d, input logic [AW-1:0] a);
      @(negedge clk);
      wdata = d;
      addr  = a;
      drive(c1, 1'b1);
      drive(c2, 1'b1);
      @(negedge clk);
      drive(c1, 1'b0);
      drive(c2, 1'b0);
   endtask

   task automatic issue(input int c, input logic [7:0] d, input logic [AW-1:0] a);
      issue2(c, c, d, a);
   endtask

   task automatic wait_idle();
      while (status[0]) @(negedge clk);
   endtask

   task automatic set_sr(input logic [7:0] d);
      issue(C_WREN, 8'h00, '0);
      issue(C_WRSR, d, '0);
      wait_idle();
   endtask

   // Busy must last exactly dur cycles counted from the start edge.
   task automatic run_len(input string req, input int dur, input logic [7:0] fin);
      chk(req, 32'(status[0]), 1);
      tick(dur - 1);
      chk(req, 32'(status[0]), 1);
      tick(1);
      chk(req, 32'(status), 32'(fin));
   endtask

   function automatic bit prot_exp(input int a, input int bpv, input int tbv);
      int sz;
      if (bpv == 0) return 1'b0;
      if (bpv == 3) return 1'b1;
      sz = 1 << (AW - FL + bpv - 1);
      if (tbv != 0) return (a < sz);
      return (a >= (1 << AW) - sz);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R2: power-up and factory reset
      factory_rst = 1'b1;
      tick(3);
      factory_rst = 1'b0;
      tick(1);
      rst_n = 1'b1;
      tick(1);
      chk("R2 reset status", 32'(status), 32'h00);
      chk("R9 reset rd_valid", 32'(rd_valid), 0);

      // R3: latch set and clear
      issue(C_WREN, 8'h00, '0);
      chk("R3 wren", 32'(status), 32'h02);
      issue(C_WRDI, 8'h00, '0);
      chk("R3 wrdi", 32'(status), 32'h00);

      // R4: status write needs the latch
      issue(C_WRSR, 8'hAC, '0);
      chk("R4 wrsr without latch", 32'(status), 32'h00);
      tick(D_SR);
      chk("R4 wrsr without latch later", 32'(status), 32'h00);
      issue(C_WREN, 8'h00, '0);
      issue(C_WRSR, 8'h2C, '0);
      chk("R4 wrsr running", 32'(status), 32'h03);
      run_len("R4 wrsr length", D_SR, 8'h2C);

      // R1: unused bit positions stay zero
      set_sr(8'hFF);
      chk("R1 layout all ones", 32'(status), 32'hAC);
      set_sr(8'h00);
      chk("R1 layout cleared", 32'(status), 32'h00);

      // R10: sweep of the protection map
      for (int t = 0; t < 2; t++) begin
         for (int b = 0; b < 4; b++) begin
            set_sr(8'((t << 5) | (b << 2)));
            chk("R10 config", 32'(status), 32'((t << 5) | (b << 2)));
            for (int a = 0; a < (1 << AW); a += 1024) begin
               for (int e = -1; e <= 0; e++) begin
                  if (a + e >= 0) begin
                     qaddr = AW'(a + e);
                     #1;
                     chk($sformatf("R10 tb=%0d bp=%0d a=%0h", t, b, a + e),
                         32'(qprot), 32'(prot_exp(a + e, b, t)));
                  end
               end
            end
         end
      end

      // R6 / R7: program and erase acceptance, top 1/8 protected
      set_sr(8'h04);
      issue(C_PP, 8'h00, AW'(0));
      chk("R7 program without latch", 32'(status), 32'h04);
      issue(C_WREN, 8'h00, '0);
      issue(C_PP, 8'h00, AW'('h1C000));
      chk("R7 program in region", 32'(status), 32'h06);
      issue(C_SE, 8'h00, AW'('h1BFFF));
      chk("R6 sector erase below region", 32'(status), 32'h07);
      run_len("R6 sector erase length", D_SE, 8'h04);
      issue(C_WREN, 8'h00, '0);
      issue(C_SE, 8'h00, AW'('h1C123));
      chk("R7 sector in region", 32'(status), 32'h06);
      issue(C_BE, 8'h00, AW'('h10000));
      chk("R7 block overlapping region", 32'(status), 32'h06);
      issue(C_CE, 8'h00, '0);
      chk("R7 chip with protection", 32'(status), 32'h06);
      issue(C_BE, 8'h00, AW'('h0FFFF));
      chk("R6 block erase accepted", 32'(status), 32'h07);
      run_len("R6 block erase length", D_BE, 8'h04);

      set_sr(8'h24);
      issue(C_WREN, 8'h00, '0);
      issue(C_PP, 8'h00, AW'('h3FFF));
      chk("R7 bottom region program", 32'(status), 32'h26);
      issue(C_PP, 8'h00, AW'('h4000));
      chk("R6 program above bottom region", 32'(status), 32'h27);
      run_len("R6 program length", D_PP, 8'h24);
      set_sr(8'h00);
      issue(C_WREN, 8'h00, '0);
      issue(C_CE, 8'h00, '0);
      run_len("R6 chip erase length", D_CE, 8'h00);

      // R8: strobes ignored while busy
      issue(C_WREN, 8'h00, '0);
      issue(C_PP, 8'h00, '0);
      issue(C_WRDI, 8'h00, '0);
      chk("R8 wrdi ignored while busy", 32'(status), 32'h03);
      wait_idle();
      chk("R8 after run", 32'(status), 32'h00);
      issue(C_WREN, 8'h00, '0);
      issue(C_PP, 8'h00, '0);
      tick(1);
      issue(C_WREN, 8'h00, '0);
      chk("R8 wren on completion edge", 32'(status), 32'h00);
      issue(C_WREN, 8'h00, '0);
      issue(C_CE, 8'h00, '0);
      issue(C_WRSR, 8'h0C, '0);
      issue(C_SE, 8'h00, '0);
      wait_idle();
      tick(2);
      chk("R8 wrsr and erase dropped", 32'(status), 32'h00);

      // R9: read response during busy and idle
      issue(C_WREN, 8'h00, '0);
      issue(C_PP, 8'h00, '0);
      issue(C_RDSR, 8'h00, '0);
      chk("R9 rd_valid busy", 32'(rd_valid), 1);
      chk("R9 rd_byte busy", 32'(rd_byte), 32'h03);
      tick(1);
      chk("R9 rd_valid drops", 32'(rd_valid), 0);
      wait_idle();
      issue(C_RDSR, 8'h00, '0);
      chk("R9 rd_byte idle", 32'(rd_byte), 32'h00);

      // R5: lock by register-protect bit and pin
      set_sr(8'h84);
      chk("R5 srp set", 32'(status), 32'h84);
      wp_n = 1'b0;
      issue(C_WREN, 8'h00, '0);
      issue(C_WRSR, 8'h20, '0);
      chk("R5 locked write runs", 32'(status), 32'h87);
      wait_idle();
      chk("R5 locked write no effect", 32'(status), 32'h84);
      wp_n = 1'b1;
      set_sr(8'h00);
      chk("R5 pin high unlocks", 32'(status), 32'h00);

      // R11: simultaneous strobes
      issue(C_WREN, 8'h00, '0);
      issue2(C_WREN, C_WRDI, 8'h00, '0);
      chk("R11 wrdi beats wren", 32'(status), 32'h00);
      issue(C_WREN, 8'h00, '0);
      issue2(C_WRSR, C_PP, 8'h08, '0);
      run_len("R11 wrsr beats program", D_SR, 8'h08);

      // R2: power-up reset keeps protection, factory reset clears it
      set_sr(8'h28);
      issue(C_WREN, 8'h00, '0);
      issue(C_PP, 8'h00, AW'('h10000));
      chk("R2 before reset", 32'(status), 32'h2B);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R2 reset keeps protection", 32'(status), 32'h28);
      tick(2);
      rst_n = 1'b1;
      tick(1);
      chk("R2 after reset", 32'(status), 32'h28);
      factory_rst = 1'b1;
      tick(1);
      factory_rst = 1'b0;
      chk("R2 factory defaults", 32'(status), 32'h00);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule